// File: doc/BRIEF.md
# Full-Duplex Dual-Channel ADC Sequencer

This block is the host-side controller for a two-input 16-bit converter with a full-duplex serial port. A start request makes it raise the converter's start line for a fixed number of clocks, which is the conversion time. It then lowers the line and runs sixteen serial clock pulses. During those pulses it reads the 16-bit result and sends a 2-bit multiplexer word on the converter's serial input.

The converter applies the word it receives to the next conversion, not to the result that is being read. The controller therefore holds the word sent in the previous transfer and uses it as the tag of each result. The first result after reset has no known configuration, so it is flagged as untagged. A word is either taken from the request inputs or, in round-robin mode, made from an internal pointer that alternates between the two single-ended channels.

Top module: `dual_adc_seq`

## Requirements
- R1: While reset is held and just after reset, adc_conv, adc_sck, adc_sdi, busy, result_valid and tag_known are all 0.
- R2: A start request in idle raises adc_conv and holds it high for exactly CONV_CYC clocks. adc_conv then falls.
- R3: After adc_conv falls, exactly DATA_W (16) pulses appear on adc_sck, each one clock low and one clock high. adc_sck stays low whenever adc_conv is high.
- R4: adc_sdi carries the single/differential bit at the first rising adc_sck edge and the channel/polarity bit at the second. It is 0 at every later rising edge of the transfer.
- R5: result holds the adc_sdo bits sampled at the sixteen rising adc_sck edges, with the first bit as the MSB. result_valid is a one-clock pulse that comes with the new result.
- R6: With rr_mode low, the sent word is {req_single, req_odd}, sampled on the clock that accepts the start. The codes are: 10 selects channel 0 against ground, 11 selects channel 1 against ground, 00 selects channel 0 positive with channel 1 negative, and 01 selects channel 1 positive with channel 0 negative.
- R7: With rr_mode high, the sent word is 10 or 11, alternating, and it starts at 10 after reset. The pointer advances only on round-robin transfers.
- R8: result_tag is the word sent in the transfer before the one that produced the result. tag_known is 0 for the first result after reset and 1 from the second result on.
- R9: A start request while busy is high has no effect: no extra conversion, and the word being sent does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request |
| req_single | input | 1 | Requested single-ended (1) or differential (0) mode |
| req_odd | input | 1 | Requested channel or polarity bit |
| rr_mode | input | 1 | Alternate the single-ended channels automatically |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Converter start line |
| adc_sck | output | 1 | Serial clock to the converter |
| adc_sdi | output | 1 | Serial multiplexer word to the converter |
| busy | output | 1 | Conversion or transfer in progress |
| result | output | DATA_W | Last conversion result |
| result_valid | output | 1 | One-clock pulse with a new result |
| result_tag | output | 2 | Configuration that produced the result |
| tag_known | output | 1 | result_tag is meaningful |

## Verification
The hardest case to reach is a tag mismatch through the one-deep pipeline. A wrong tag shows only when consecutive transfers send different words, and only if the converter really applies each word one conversion late. The bench contains a behavioural converter that captures the word from adc_sdi and makes each result from the configuration it actually applied. A table of mixed manual and round-robin requests then forces every code to follow a different one. A start pulse in the middle of a transfer, with a conflicting request, exercises the ignored-start case.

// File: rtl/dual_adc_seq_pkg.sv
package dual_adc_seq_pkg;
  typedef struct packed {
    logic single;
    logic odd;
  } mux_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_XFER = 2'd2
  } seq_state_t;
endpackage

// File: rtl/dual_adc_seq_rstsync.sv
module dual_adc_seq_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/dual_adc_seq_serial.sv
module dual_adc_seq_serial
  import dual_adc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  mux_cfg_t          cfg_i,
  input  logic              sdo_i,
  output logic              conv_o,
  output logic              sck_o,
  output logic              sdi_o,
  output logic              busy_o,
  output logic              accept_o,
  output logic              fin_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(CONV_CYC + 1);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_END  = CNT_W'(CONV_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

  seq_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              sck_q, sck_d;
  logic              sdi_q, sdi_d;
  logic              conv_q, conv_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic [DATA_W-1:0] data_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign fin_o    = (state_q == ST_XFER) && sck_q && (bit_q == BIT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    bit_d   = bit_q;
    sck_d   = sck_q;
    sdi_d   = sdi_q;
    conv_d  = conv_q;
    shift_d = shift_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_CONV;
          conv_d  = 1'b1;
          cnt_d   = '0;
        end
      end
      ST_CONV: begin
        if (cnt_q == CNT_END) begin
          state_d = ST_XFER;
          conv_d  = 1'b0;
          sck_d   = 1'b0;
          bit_d   = '0;
          sdi_d   = cfg_i.single;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_XFER: begin
        if (!sck_q) begin
          sck_d   = 1'b1;
          shift_d = {shift_q[DATA_W-2:0], sdo_i};
        end else begin
          sck_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            state_d = ST_IDLE;
            sdi_d   = 1'b0;
          end else begin
            bit_d = bit_q + 1'b1;
            sdi_d = (bit_q == '0) ? cfg_i.odd : 1'b0;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sck_q   <= 1'b0;
      sdi_q   <= 1'b0;
      conv_q  <= 1'b0;
      shift_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bit_q   <= bit_d;
      sck_q   <= sck_d;
      sdi_q   <= sdi_d;
      conv_q  <= conv_d;
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (fin_o) data_q <= shift_q;
  end

  assign conv_o = conv_q;
  assign sck_o  = sck_q;
  assign sdi_o  = sdi_q;
  assign busy_o = (state_q != ST_IDLE);
  assign data_o = data_q;
endmodule

// File: rtl/dual_adc_seq_tagger.sv
module dual_adc_seq_tagger
  import dual_adc_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept_i,
  input  logic     fin_i,
  input  logic     rr_i,
  input  mux_cfg_t req_i,
  output mux_cfg_t cur_o,
  output mux_cfg_t tag_o,
  output logic     known_o,
  output logic     valid_o
);
  mux_cfg_t cur_q, cur_d;
  mux_cfg_t prev_q, tag_q;
  logic     prev_v_q, known_q, valid_q, rr_ptr_q;

  always_comb begin
    cur_d = cur_q;
    if (accept_i) begin
      if (rr_i) cur_d = '{single: 1'b1, odd: rr_ptr_q};
      else      cur_d = req_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      rr_ptr_q <= 1'b0;
    end else begin
      cur_q <= cur_d;
      if (accept_i && rr_i) rr_ptr_q <= ~rr_ptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      prev_v_q <= 1'b0;
      tag_q    <= '0;
      known_q  <= 1'b0;
    end else if (fin_i) begin
      tag_q    <= prev_q;
      known_q  <= prev_v_q;
      prev_q   <= cur_q;
      prev_v_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= fin_i;
  end

  assign cur_o   = cur_q;
  assign tag_o   = tag_q;
  assign known_o = known_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
  import dual_adc_seq_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int CONV_CYC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              req_single,
  input  logic              req_odd,
  input  logic              rr_mode,
  input  logic              adc_sdo,
  output logic              adc_conv,
  output logic              adc_sck,
  output logic              adc_sdi,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              result_valid,
  output logic [1:0]        result_tag,
  output logic              tag_known
);
  logic     rst_n_int, accept, fin;
  mux_cfg_t req_cfg, cur_cfg, tag_cfg;

  assign req_cfg = '{single: req_single, odd: req_odd};

  dual_adc_seq_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dual_adc_seq_serial #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u_ser (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .start_i  (start),
    .cfg_i    (cur_cfg),
    .sdo_i    (adc_sdo),
    .conv_o   (adc_conv),
    .sck_o    (adc_sck),
    .sdi_o    (adc_sdi),
    .busy_o   (busy),
    .accept_o (accept),
    .fin_o    (fin),
    .data_o   (result)
  );

  dual_adc_seq_tagger u_tag (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .accept_i (accept),
    .fin_i    (fin),
    .rr_i     (rr_mode),
    .req_i    (req_cfg),
    .cur_o    (cur_cfg),
    .tag_o    (tag_cfg),
    .known_o  (tag_known),
    .valid_o  (result_valid)
  );

  assign result_tag = tag_cfg;
endmodule

// File: rtl/dual_adc_seq_chk.sv
module dual_adc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic adc_conv,
  input logic adc_sck,
  input logic adc_sdi,
  input logic busy,
  input logic result_valid,
  input logic tag_known
);
  assert_sck_low_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> !adc_sck);

  assert_conv_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_conv) |=> adc_conv);

  assert_conv_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    adc_conv |-> busy);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!adc_sdi && !adc_sck && !adc_conv));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);

  assert_tag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tag_known |=> tag_known);
endmodule

bind dual_adc_seq dual_adc_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .adc_conv     (adc_conv),
  .adc_sck      (adc_sck),
  .adc_sdi      (adc_sdi),
  .busy         (busy),
  .result_valid (result_valid),
  .tag_known    (tag_known)
);

// File: tb/sim_dual_adc_seq.sv
module sim_dual_adc_seq;
  localparam int DATA_W   = 16;
  localparam int CONV_CYC = 8;
  localparam int NVEC     = 8;
  // Each entry: {rr_mode, req_single, req_odd}
  localparam logic [2:0] VEC [NVEC] = '{3'b010, 3'b011, 3'b000, 3'b001,
                                        3'b100, 3'b100, 3'b011, 3'b100};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, req_single = 1'b0, req_odd = 1'b0, rr_mode = 1'b0;
  logic adc_sdo, adc_conv, adc_sck, adc_sdi, busy, result_valid, tag_known;
  logic [DATA_W-1:0] result;
  logic [1:0] result_tag;

  int checks = 0, errors = 0, cycles = 0;

  always #5 clk = ~clk;

  dual_adc_seq #(.DATA_W(DATA_W), .CONV_CYC(CONV_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .req_single(req_single),
    .req_odd(req_odd), .rr_mode(rr_mode), .adc_sdo(adc_sdo),
    .adc_conv(adc_conv), .adc_sck(adc_sck), .adc_sdi(adc_sdi), .busy(busy),
    .result(result), .result_valid(result_valid), .result_tag(result_tag),
    .tag_known(tag_known)
  );

  function automatic logic [15:0] mk(input logic [1:0] cfg, input int seq);
    mk = {cfg, 14'h0} ^ 16'(seq * 16'h2B5D + 16'h0F3C);
  endfunction

  // Behavioural converter
  logic [1:0]  m_pend = 2'b10;
  logic [1:0]  m_cap = 2'b00;
  logic [15:0] m_sh = '0;
  logic        m_sdo = 1'b0;
  logic        m_sdi_bad = 1'b0;
  int          m_seq = 0, m_edges = 0;

  always @(posedge adc_conv) begin
    m_sh  = mk(m_pend, m_seq);
    m_seq = m_seq + 1;
  end
  always @(negedge adc_conv) begin
    m_edges = 0;
    m_sdo   = m_sh[15];
  end
  always @(posedge adc_sck) if (!adc_conv) begin
    m_edges = m_edges + 1;
    if (m_edges == 1) m_cap[1] = adc_sdi;
    if (m_edges == 2) begin m_cap[0] = adc_sdi; m_pend = m_cap; end
    if (m_edges > 2 && adc_sdi) m_sdi_bad = 1'b1;
  end
  always @(negedge adc_sck) if (!adc_conv) begin
    m_sh  = {m_sh[14:0], 1'b0};
    m_sdo = m_sh[15];
  end
  assign adc_sdo = adc_conv ? 1'b0 : m_sdo;

  // conv high length
  int conv_len = 0, conv_last = 0;
  always @(negedge clk) begin
    cycles = cycles + 1;
    if (adc_conv) conv_len = conv_len + 1;
    else if (conv_len != 0) begin conv_last = conv_len; conv_len = 0; end
  end

  always @(negedge clk) if (cycles > 150000) begin
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [1:0] prev_sent = 2'b10;
  bit         have_prev = 1'b0;
  bit         bench_rr = 1'b0;
  int         exp_seq = 0;

  task automatic wait_result(output bit got);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (result_valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_one(input logic [2:0] v, input bit poke_busy);
    logic [1:0] sent;
    bit got;
    int seq_before;
    if (v[2]) begin sent = {1'b1, bench_rr}; bench_rr = ~bench_rr; end
    else      sent = v[1:0];
    seq_before = m_seq;
    m_sdi_bad  = 1'b0;
    @(negedge clk);
    rr_mode = v[2]; req_single = v[1]; req_odd = v[0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (12) @(negedge clk);
      rr_mode = 1'b0; req_single = ~sent[1]; req_odd = ~sent[0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_result(got);
    chk(got, "R5 result_valid seen", got, 1);
    chk(result == mk(prev_sent, exp_seq), "R5 R8 result data", result, mk(prev_sent, exp_seq));
    chk(m_cap == sent, "R4 R6 R7 word sent", m_cap, sent);
    chk(!m_sdi_bad, "R4 sdi zero after two bits", m_sdi_bad, 0);
    chk(m_edges == DATA_W, "R3 sck pulses", m_edges, DATA_W);
    chk(conv_last == CONV_CYC, "R2 conv length", conv_last, CONV_CYC);
    chk(tag_known == have_prev, "R8 tag_known", tag_known, have_prev);
    if (have_prev) chk(result_tag == prev_sent, "R8 tag", result_tag, prev_sent);
    @(negedge clk);
    chk(!result_valid, "R5 valid one clock", result_valid, 0);
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      chk(m_seq == seq_before + 1 && !busy, "R9 start ignored while busy", m_seq, seq_before + 1);
    end
    prev_sent = sent;
    have_prev = 1'b1;
    exp_seq   = exp_seq + 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!adc_conv && !adc_sck && !adc_sdi && !busy && !result_valid && !tag_known,
        "R1 state in reset", {adc_conv, adc_sck, adc_sdi, busy, result_valid, tag_known}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!adc_conv && !adc_sck && !busy && !tag_known, "R1 state after reset",
        {adc_conv, adc_sck, busy, tag_known}, 0);

    for (int i = 0; i < NVEC; i++) run_one(VEC[i], 1'b0);

    // R9: mid-transfer start with a conflicting request
    run_one(3'b001, 1'b1);
    // R7: pointer continues after a manual transfer
    run_one(3'b100, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule